// File: doc/BRIEF.md
# Two-wire serial shift channel

This block is the master side of a byte shifter for a two-wire open-drain bus: one clock line and one data line, each pulled up externally and only ever pulled low by any device. Software drives it through three small registers: a shift register, a control/status register and a clock divider. Writing the shift register while the channel is enabled and idle launches an 8-bit exchange. The byte goes out most significant bit first. The bits coming back from the line are shifted in at the same time. When the eighth bit is done, the clock stops low and a completion flag raises the interrupt output.

Start and stop conditions are not generated automatically. Software builds them from two control bits. One releases the clock line high and suppresses all clock pulses while set. The other pulls the data line low while the shifter is idle. A status bit returns the sampled level of the clock pin. With it, the master can see that the line really rose, or that a slave is stretching the clock. The shifter also waits at every rising clock edge until the pin is actually high, so a stretching slave simply pauses the byte.

For reception, software writes all-ones. Since a 1 bit never pulls the line, the data line stays released and the returned byte is whatever the slave put on the bus.

Top module: `twowire_shifter`

## Requirements
- R1: A write to the shift register (address 0) starts a transfer only when the enable bit (control bit 0) is 1 and no transfer is in progress. Busy then reads 1 in control bit 5. Writes to address 0 during a transfer are ignored and do not alter the byte on the line.
- R2: A shift-register write made while enable is 0 starts nothing. Setting enable afterwards does not launch it either: busy, the flag and the clock output all stay idle.
- R3: A transfer makes exactly 8 clock pulses and sends the written byte MSB first. The data output changes only while the clock pin is low. After the eighth pulse busy clears and the completion flag (control bit 3, also the `irq` output) is set.
- R4: While no transfer runs and the clock-force bit is 0, the clock output pulls SCL low.
- R5: Control bit 1 set to 1 releases SCL high and freezes any transfer, so that no clock edge occurs. Clearing it returns SCL low and lets the transfer resume. Control bit 2 set to 1 pulls SDA low while idle.
- R6: Control bit 4 reads the SCL pin level sampled one clock earlier. It reads 0 when a slave holds the line low against a released master.
- R7: When a slave holds SCL low, the shifter waits without losing data. A byte written during the hold is sent in full once the line is let go.
- R8: Writing 0xFF to the shift register leaves SDA released (never pulled low) for the whole transfer.
- R9: After completion, a read of address 0 returns the received byte: the bits sampled on SDA at each rising SCL, MSB first. Writing control with bit 3 = 0 clears the flag. Writing bit 3 = 1 leaves it unchanged.
- R10: Between clock pulses of a transfer, SCL is held low for exactly N system clocks. N is the divider register (address 2, reset value 4), and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 shift, 1 control, 2 divider) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Transfer-complete flag |
| scl_low | output | 1 | 1 pulls the SCL line low |
| sda_low | output | 1 | 1 pulls the SDA line low |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The assertions assume that `scl_in` and `sda_in` are the wired levels of the lines that `scl_low` and `sda_low` help drive. They also assume that software does not rewrite the divider or toggle the clock-force bit while a clock high phase is under way. The stimulus respects both points. The bench forms each pin as the wired-AND of the master output and a modelled slave. It writes the divider only between transfers, and it sets clock-force before a launch or clears it while the shifter is frozen in a low phase. Slave stretching is applied only while the line is low, as a real slave would do.

// File: rtl/twowire_shifter.sv
`timescale 1ns/1ps
module twowire_shifter #(
  parameter int DIVW = 8,
  parameter logic [DIVW-1:0] DIV_RST = DIVW'(4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       scl_in,
  input  logic       sda_in
);
  logic [7:0]      shreg;
  logic [DIVW-1:0] div, cnt, lim;
  logic [2:0]      bitcnt;
  logic en, clk_hi, sda_hold, flag, busy, phase_hi, rxbit, scl_s, sda_s;
  logic wr_sh, wr_ctl, wr_div, launch, last;

  assign wr_sh  = reg_wr && reg_addr == 2'd0;
  assign wr_ctl = reg_wr && reg_addr == 2'd1;
  assign wr_div = reg_wr && reg_addr == 2'd2;
  assign launch = wr_sh && en && !busy;
  assign lim    = (div == '0) ? DIVW'(1) : div;
  assign last   = cnt == lim - DIVW'(1);

  assign irq     = flag;
  assign scl_low = !(clk_hi || (busy && phase_hi));
  assign sda_low = busy ? !shreg[7] : sda_hold;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = shreg;
      2'd1:    reg_rdata = {2'b00, busy, scl_s, flag, sda_hold, clk_hi, en};
      2'd2:    reg_rdata = 8'(div);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; div <= DIV_RST; cnt <= '0; bitcnt <= '0;
      en <= 1'b0; clk_hi <= 1'b0; sda_hold <= 1'b0; flag <= 1'b0;
      busy <= 1'b0; phase_hi <= 1'b0; rxbit <= 1'b0;
      scl_s <= 1'b0; sda_s <= 1'b0;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      if (wr_ctl) begin
        en       <= reg_wdata[0];
        clk_hi   <= reg_wdata[1];
        sda_hold <= reg_wdata[2];
        if (!reg_wdata[3]) flag <= 1'b0;
      end
      if (wr_div) div <= reg_wdata[DIVW-1:0];
      if (wr_sh && !busy) shreg <= reg_wdata;
      if (launch) begin
        busy <= 1'b1; phase_hi <= 1'b0; cnt <= '0; bitcnt <= '0;
      end else if (busy && !clk_hi) begin
        if (!phase_hi) begin
          if (last) begin phase_hi <= 1'b1; cnt <= '0; end
          else cnt <= cnt + DIVW'(1);
        end else if (scl_s) begin
          if (cnt == '0) rxbit <= sda_s;
          if (last) begin
            shreg    <= {shreg[6:0], (cnt == '0) ? sda_s : rxbit};
            phase_hi <= 1'b0;
            cnt      <= '0;
            bitcnt   <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin busy <= 1'b0; flag <= 1'b1; end
          end else cnt <= cnt + DIVW'(1);
        end
      end
    end
  end

  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && !phase_hi && bitcnt == 3'd0);
  p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh && !en && !busy) |=> !busy);
  p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag && bitcnt == 3'd0);
  p_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_hi && scl_s && !last && !clk_hi) |=> $stable(sda_low));
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_hi) |=> $stable(bitcnt) && $stable(phase_hi) && busy);
  p_stretch_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_hi && !scl_s && !clk_hi) |=> $stable(shreg) && $stable(bitcnt) && phase_hi);
endmodule

// File: tb/tb_twowire_shifter.sv
`timescale 1ns/1ps
module tb_twowire_shifter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, scl_low, sda_low;
  logic hold = 1'b0, slv_on = 1'b0, in_xfer = 1'b0, done = 1'b0;
  logic [7:0] slv_byte = 8'hFF, cap = 8'h00;
  logic [3:0] sidx = 4'd0;
  int nchk = 0, nerr = 0, nrise = 0, nrun = 0, lowrun = 0, baddiv = 0, badsda = 0, sdadrv = 0, expdiv = 1;
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  wire scl_pin = !(scl_low || hold);
  wire slv_pull = slv_on && sidx < 4'd8 && !slv_byte[3'(3'd7 - sidx[2:0])];
  wire sda_pin = !(sda_low || slv_pull);

  twowire_shifter dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_low(scl_low),
    .sda_low(sda_low), .scl_in(scl_pin), .sda_in(sda_pin));

  always #5 clk = ~clk;

  always @(negedge scl_pin) if (slv_on) sidx = sidx + 4'd1;
  always @(posedge scl_pin) begin cap = {cap[6:0], ~sda_low}; nrise++; end

  always @(negedge clk) begin
    if (scl_low) lowrun++;
    else begin
      if (lowrun != 0) begin nrun++; if (nrun > 1 && lowrun != expdiv) baddiv++; end
      lowrun = 0;
    end
    if (in_xfer && prev_scl && scl_pin && sda_low != prev_sda) badsda++;
    if (in_xfer && sda_low) sdadrv++;
    prev_scl = scl_pin; prev_sda = sda_low;
  end

  function automatic logic [7:0] exp_rx(input logic [7:0] t, input logic [7:0] s);
    return t & s;
  endfunction
  function automatic int exp_lowrun(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_flag(input string tag);
    int n;
    n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk({tag, " completion flag"}, int'(irq), 1);
  endtask

  task automatic arm(input logic [7:0] slv, input logic [7:0] dv);
    wr(2'd2, dv);
    expdiv = exp_lowrun(dv);
    slv_byte = slv; slv_on = 1'b1; sidx = 4'd0; cap = 8'h00;
    nrise = 0; nrun = 0; lowrun = 0; baddiv = 0; badsda = 0; sdadrv = 0;
    in_xfer = 1'b1;
  endtask

  task automatic finish_xfer(output logic [7:0] rx);
    in_xfer = 1'b0; slv_on = 1'b0;
    rd(2'd0, rx);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input logic [7:0] dv,
                      input bit poke, output logic [7:0] rx);
    arm(slv, dv);
    wr(2'd0, tx);
    if (poke) wr(2'd0, ~tx);
    wait_flag("R3");
    finish_xfer(rx);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, rx;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("reset control R4", int'(v), 'h00);
    rd(2'd2, v); chk("reset divider R10", int'(v), 4);
    chk("reset scl_low R4", int'(scl_low), 1);
    chk("reset sda_low", int'(sda_low), 0);
    chk("reset irq R3", int'(irq), 0);

    wr(2'd0, 8'h5A);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R2 no busy while disabled", int'(v[5]), 0);
    wr(2'd1, 8'h01);
    repeat (30) @(negedge clk);
    rd(2'd1, v); chk("R2 enable does not launch", int'(v[5]), 0);
    chk("R2 irq idle", int'(irq), 0);
    chk("R2 scl held low", int'(scl_low), 1);

    arm(8'hFF, 8'd2);
    wr(2'd0, 8'hA5);
    rd(2'd1, v); chk("R1 busy after write", int'(v[5]), 1);
    wait_flag("R3");
    finish_xfer(rx);
    chk("R3 byte on line", int'(cap), 'hA5);
    chk("R3 eight pulses", nrise, 8);
    chk("R3 sda steady while high", badsda, 0);
    chk("R9 received byte", int'(rx), int'(exp_rx(8'hA5, 8'hFF)));
    chk("R10 low phase length", baddiv, 0);
    rd(2'd1, v); chk("R3 busy cleared", int'(v[5]), 0);
    chk("R4 idle scl low", int'(scl_low), 1);
    wr(2'd1, 8'h09);
    chk("R9 writing 1 keeps flag", int'(irq), 1);
    wr(2'd1, 8'h01);
    chk("R9 writing 0 clears flag", int'(irq), 0);

    xfer(8'hFF, 8'h3C, 8'd3, 1'b0, rx);
    chk("R8 sda never pulled", sdadrv, 0);
    chk("R9 reception byte", int'(rx), 'h3C);
    wr(2'd1, 8'h01);

    wr(2'd1, 8'h05);
    chk("R5 sda held low idle", int'(sda_low), 1);
    wr(2'd1, 8'h03);
    chk("R5 force releases scl", int'(scl_low), 0);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R6 status reads high", int'(v[4]), 1);
    hold = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R6 status sees slave hold", int'(v[4]), 0);
    hold = 1'b0;
    repeat (2) @(negedge clk);
    arm(8'hFF, 8'd2);
    wr(2'd0, 8'h81);
    repeat (50) @(negedge clk);
    chk("R5 no pulses while forced", nrise, 0);
    chk("R5 no completion while forced", int'(irq), 0);
    rd(2'd1, v); chk("R5 transfer pending", int'(v[5]), 1);
    wr(2'd1, 8'h01);
    chk("R5 clear returns scl low", int'(scl_low), 1);
    wait_flag("R5");
    finish_xfer(rx);
    chk("R5 byte after release", int'(cap), 'h81);
    chk("R5 received", int'(rx), 'h81);
    wr(2'd1, 8'h01);

    hold = 1'b1;
    arm(8'hFF, 8'd2);
    wr(2'd0, 8'hC3);
    repeat (60) @(negedge clk);
    chk("R7 no pulses during hold", nrise, 0);
    chk("R7 no completion during hold", int'(irq), 0);
    rd(2'd1, v); chk("R7 still busy", int'(v[5]), 1);
    hold = 1'b0;
    wait_flag("R7");
    finish_xfer(rx);
    chk("R7 byte kept and sent", int'(cap), 'hC3);
    chk("R7 received", int'(rx), 'hC3);
    wr(2'd1, 8'h01);

    for (int i = 0; i < 24; i++) begin
      logic [7:0] t, s, d;
      t = 8'($urandom_range(0, 255));
      s = 8'($urandom_range(0, 255));
      d = 8'($urandom_range(0, 4));
      xfer(t, s, d, (i % 3) == 0, rx);
      chk("R1 R3 random byte on line", int'(cap), int'(t));
      chk("R3 random pulse count", nrise, 8);
      chk("R3 random sda steady", badsda, 0);
      chk("R9 random received", int'(rx), int'(exp_rx(t, s)));
      chk("R10 random low phase", baddiv, 0);
      wr(2'd1, 8'h01);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule